// File: doc/BRIEF.md
# Receive Frame Status Queue

This block keeps a short history of received HDLC/SDLC frames so that software can fall behind the line by several frames and still recover each frame's length and error status. A running byte counter follows the current frame. When the receiver signals the end of a frame, the counter value and the frame's error bits are stored as one entry in a ten-entry circular queue. Software reads the oldest entry through three status bytes and then pulses a read-complete input, which retires that entry.

The read side chooses between two sources. While the queue is enabled and holds at least one entry, the length and the queued error bits come from the oldest entry. Otherwise they come from the live counter and the live status inputs. The transmitter-drained flag, the parity-error flag and the end-of-frame flag never enter the queue and are always shown live. A sticky overflow flag reports a frame that ended while all ten slots were taken.

The queue occupancy is a four-state machine. OFF is held while the enable input is low. EMPTY is entered from OFF on enable, or from PARTIAL when a retire empties the queue. PARTIAL is entered from EMPTY on a store, or from FULL on a retire. FULL is entered from PARTIAL when a store fills the last slot. FULL stays FULL on a store with no retire (this is the overflow transition). Any state goes to OFF when the enable input drops.

Top module: `frame_status_queue`

## Requirements
- R1: The byte counter clears to 0 on `flag_det`. Otherwise it adds one on each `byte_stb` cycle, but only while `sdlc_mode` is 1. A cycle with both `flag_det` and `byte_stb` leaves 0.
- R2: With `fifo_en` high, an `eof_stb` cycle stores one entry. The entry holds the counter value as it stood before that cycle, together with `live_resid`, `live_ovr` and `live_crc` sampled in that cycle.
- R3: Entries are read out oldest first. A `status_read_done` pulse retires the shown entry. A `status_read_done` pulse while the queue is empty changes nothing.
- R4: `cnt_hi[6]` is 1 exactly when `fifo_en` is 1 and the queue holds at least one entry.
- R5: When `cnt_hi[6]` is 0, the count bytes show the running counter and the queued status fields show the live inputs.
- R6: `st_reg[0]` always equals `live_all_sent`, `st_reg[4]` always equals `live_parity`, and `st_reg[7]` always equals `live_eof`, whatever the queue holds.
- R7: The queue holds 10 entries. An `eof_stb` with 10 entries held and no retire in the same cycle is dropped, the stored entries are kept, and `cnt_hi[7]` becomes 1 and stays 1.
- R8: A cycle with `fifo_en` low empties the queue and clears `cnt_hi[7]`. An `eof_stb` while `fifo_en` is low stores nothing.
- R9: After reset, all three output bytes are 0 while the live inputs are 0.
- R10: The field layout is as follows. `st_reg` bit 7 is eof, bit 6 is crc, bit 5 is overrun, bit 4 is parity, bits 3:1 are residue and bit 0 is all-sent. `cnt_lo` holds count bits 7:0. `cnt_hi` bits 5:0 hold count bits 13:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdlc_mode | input | 1 | Enables byte counting |
| flag_det | input | 1 | Flag seen; clears the byte counter |
| byte_stb | input | 1 | One received byte |
| eof_stb | input | 1 | End of frame; stores an entry |
| live_resid | input | 3 | Live residue code |
| live_ovr | input | 1 | Live receive overrun |
| live_crc | input | 1 | Live CRC error |
| live_all_sent | input | 1 | Live transmitter-drained flag (bypass) |
| live_parity | input | 1 | Live parity error (bypass) |
| live_eof | input | 1 | Live end-of-frame flag (bypass) |
| fifo_en | input | 1 | Queue enable; low flushes the queue |
| status_read_done | input | 1 | Retires the oldest entry |
| st_reg | output | 8 | Status byte |
| cnt_lo | output | 8 | Count bits 7:0 |
| cnt_hi | output | 8 | Overflow flag, data-available flag, count bits 13:8 |

## Verification
The hardest condition to reach is a frame ending into a full queue, because it needs ten unretired frames followed by an eleventh. The stimulus stores eleven frames whose lengths are 1 to 11 with no retires in between, checks the sticky flag, and then drains the queue to confirm that lengths 1 to 10 survive and length 11 is gone. A frame of 300 bytes exercises the upper count byte. Reads taken while the live bypass inputs disagree with the queued bits show the source split.

// File: rtl/fsq_pkg.sv
package fsq_pkg;
    parameter int FSQ_CNT_W = 14;
    parameter int FSQ_DEPTH = 10;

    typedef struct packed {
        logic [2:0] resid;
        logic       ovr;
        logic       crc;
    } fsq_stat_t;

    typedef enum logic [1:0] {
        Q_OFF     = 2'd0,
        Q_EMPTY   = 2'd1,
        Q_PARTIAL = 2'd2,
        Q_FULL    = 2'd3
    } fsq_state_t;
endpackage

// File: rtl/fsq_byte_counter.sv
module fsq_byte_counter #(
    parameter int CNT_W = fsq_pkg::FSQ_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sdlc_mode,
    input  logic             flag_det,
    input  logic             byte_stb,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (flag_det)
            count <= '0;
        else if (byte_stb && sdlc_mode)
            count <= count + 1'b1;
    end

    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        flag_det |=> (count == '0)); // R1
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb && sdlc_mode && !flag_det) |=> (count == $past(count) + 1'b1)); // R1
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sdlc_mode && !flag_det) |=> $stable(count)); // R1
endmodule

// File: rtl/fsq_ring.sv
module fsq_ring
    import fsq_pkg::*;
#(
    parameter int CNT_W = FSQ_CNT_W,
    parameter int DEPTH = FSQ_DEPTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             push,
    input  logic             pop_req,
    input  logic [CNT_W-1:0] wr_cnt,
    input  fsq_stat_t        wr_stat,
    output logic [CNT_W-1:0] rd_cnt,
    output fsq_stat_t        rd_stat,
    output logic             not_empty,
    output logic             overflow
);
    localparam int PTR_W   = $clog2(DEPTH);
    localparam int ENTRY_W = CNT_W + $bits(fsq_stat_t);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    fsq_state_t       state, state_n;
    logic [PTR_W-1:0] head, tail, head_n, tail_n;
    logic             holding, do_push, do_pop, drop;
    logic [ENTRY_W-1:0] mem [DEPTH];

    function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign holding = (state == Q_PARTIAL) || (state == Q_FULL);
    assign do_pop  = enable && pop_req && holding;
    assign do_push = enable && push && ((state != Q_FULL) || do_pop);
    assign drop    = enable && push && (state == Q_FULL) && !do_pop;
    assign head_n  = do_push ? step_ptr(head) : head;
    assign tail_n  = do_pop  ? step_ptr(tail) : tail;

    always_comb begin
        state_n = state;
        unique case (state)
            Q_OFF, Q_EMPTY:
                state_n = do_push ? Q_PARTIAL : Q_EMPTY;
            Q_PARTIAL:
                if (do_push && !do_pop && (head_n == tail))
                    state_n = Q_FULL;
                else if (do_pop && !do_push && (tail_n == head))
                    state_n = Q_EMPTY;
                else
                    state_n = Q_PARTIAL;
            Q_FULL:
                state_n = (do_pop && !do_push) ? Q_PARTIAL : Q_FULL;
        endcase
        if (!enable)
            state_n = Q_OFF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= Q_OFF;
            head     <= '0;
            tail     <= '0;
            overflow <= 1'b0;
        end else if (!enable) begin
            state    <= Q_OFF;
            head     <= '0;
            tail     <= '0;
            overflow <= 1'b0;
        end else begin
            state <= state_n;
            head  <= head_n;
            tail  <= tail_n;
            if (drop)
                overflow <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push)
            mem[head] <= {wr_cnt, wr_stat};
    end

    always_comb begin
        not_empty = enable && holding;
        {rd_cnt, rd_stat} = mem[tail];
    end

    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (head < DEPTH) && (tail < DEPTH)); // R3
    AST_EMPTY_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state == Q_EMPTY && !push) |=> (tail == $past(tail) && state == Q_EMPTY)); // R3
    AST_NO_OVERFLOW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state == Q_FULL && push && !pop_req) |=> (head == $past(head) && overflow)); // R7
    AST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (state == Q_OFF && !overflow && head == tail)); // R8
    AST_EMPTY_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == Q_EMPTY) |-> (head == tail)); // R4
endmodule

// File: rtl/fsq_readmux.sv
module fsq_readmux
    import fsq_pkg::*;
#(
    parameter int CNT_W = FSQ_CNT_W
) (
    input  logic             avail,
    input  logic             ovf,
    input  logic [CNT_W-1:0] q_cnt,
    input  fsq_stat_t        q_stat,
    input  logic [CNT_W-1:0] live_cnt,
    input  fsq_stat_t        live_stat,
    input  logic             live_all_sent,
    input  logic             live_parity,
    input  logic             live_eof,
    output logic [7:0]       st_reg,
    output logic [7:0]       cnt_lo,
    output logic [7:0]       cnt_hi
);
    localparam int HI_W = CNT_W - 8;

    logic [CNT_W-1:0] sel_cnt;
    fsq_stat_t        sel_stat;

    always_comb begin
        sel_cnt  = avail ? q_cnt  : live_cnt;
        sel_stat = avail ? q_stat : live_stat;
        st_reg   = {live_eof, sel_stat.crc, sel_stat.ovr, live_parity,
                    sel_stat.resid, live_all_sent};
        cnt_lo   = sel_cnt[7:0];
        cnt_hi   = {ovf, avail, sel_cnt[CNT_W-1:8]};
    end

    initial assert (HI_W == 6) else $error("count width must be 14");
endmodule

// File: rtl/frame_status_queue.sv
module frame_status_queue
    import fsq_pkg::*;
#(
    parameter int CNT_W = FSQ_CNT_W,
    parameter int DEPTH = FSQ_DEPTH
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sdlc_mode,
    input  logic       flag_det,
    input  logic       byte_stb,
    input  logic       eof_stb,
    input  logic [2:0] live_resid,
    input  logic       live_ovr,
    input  logic       live_crc,
    input  logic       live_all_sent,
    input  logic       live_parity,
    input  logic       live_eof,
    input  logic       fifo_en,
    input  logic       status_read_done,
    output logic [7:0] st_reg,
    output logic [7:0] cnt_lo,
    output logic [7:0] cnt_hi
);
    logic [CNT_W-1:0] run_cnt, q_cnt;
    fsq_stat_t        live_stat, q_stat;
    logic             avail, ovf;

    assign live_stat = '{resid: live_resid, ovr: live_ovr, crc: live_crc};

    fsq_byte_counter #(.CNT_W(CNT_W)) i_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .sdlc_mode (sdlc_mode),
        .flag_det  (flag_det),
        .byte_stb  (byte_stb),
        .count     (run_cnt)
    );

    fsq_ring #(.CNT_W(CNT_W), .DEPTH(DEPTH)) i_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (fifo_en),
        .push      (eof_stb),
        .pop_req   (status_read_done),
        .wr_cnt    (run_cnt),
        .wr_stat   (live_stat),
        .rd_cnt    (q_cnt),
        .rd_stat   (q_stat),
        .not_empty (avail),
        .overflow  (ovf)
    );

    fsq_readmux #(.CNT_W(CNT_W)) i_mux (
        .avail         (avail),
        .ovf           (ovf),
        .q_cnt         (q_cnt),
        .q_stat        (q_stat),
        .live_cnt      (run_cnt),
        .live_stat     (live_stat),
        .live_all_sent (live_all_sent),
        .live_parity   (live_parity),
        .live_eof      (live_eof),
        .st_reg        (st_reg),
        .cnt_lo        (cnt_lo),
        .cnt_hi        (cnt_hi)
    );

    AST_STORE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && eof_stb && !avail) |=> (fifo_en -> {cnt_hi[5:0], cnt_lo} == $past(run_cnt))); // R2
    AST_DISABLED_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |=> !cnt_hi[7]); // R8
endmodule

// File: tb/test_frame_status_queue.sv
module test_frame_status_queue;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sdlc_mode = 1'b0, flag_det = 1'b0, byte_stb = 1'b0, eof_stb = 1'b0;
    logic [2:0] live_resid = 3'd0;
    logic       live_ovr = 1'b0, live_crc = 1'b0;
    logic       live_all_sent = 1'b0, live_parity = 1'b0, live_eof = 1'b0;
    logic       fifo_en = 1'b0, status_read_done = 1'b0;
    logic [7:0] st_reg, cnt_lo, cnt_hi;

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;

    int       m_cnt;
    int       mq_len[$];
    int       mq_st[$];
    bit       m_ovf;

    always #10 clk = ~clk;

    frame_status_queue i_frame_status_queue (
        .clk(clk), .rst_n(rst_n), .sdlc_mode(sdlc_mode), .flag_det(flag_det),
        .byte_stb(byte_stb), .eof_stb(eof_stb), .live_resid(live_resid),
        .live_ovr(live_ovr), .live_crc(live_crc), .live_all_sent(live_all_sent),
        .live_parity(live_parity), .live_eof(live_eof), .fifo_en(fifo_en),
        .status_read_done(status_read_done), .st_reg(st_reg), .cnt_lo(cnt_lo),
        .cnt_hi(cnt_hi)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        int old = m_cnt;
        bit full;
        bit pop;
        if (!rst_n) begin
            m_cnt = 0; m_ovf = 0; mq_len.delete(); mq_st.delete();
            return;
        end
        if (flag_det) m_cnt = 0;
        else if (byte_stb && sdlc_mode) m_cnt = (m_cnt + 1) % 16384;
        if (!fifo_en) begin
            mq_len.delete(); mq_st.delete(); m_ovf = 0;
        end else begin
            full = (mq_len.size() == 10);
            pop  = status_read_done && (mq_len.size() > 0);
            if (pop) begin
                void'(mq_len.pop_front()); void'(mq_st.pop_front());
            end
            if (eof_stb) begin
                if (full && !pop) m_ovf = 1;
                else begin
                    mq_len.push_back(old);
                    mq_st.push_back({live_resid, live_ovr, live_crc});
                end
            end
        end
    endtask

    task automatic compare();
        bit avail = fifo_en && (mq_len.size() > 0);
        int ecnt = avail ? mq_len[0] : m_cnt;
        int est  = avail ? mq_st[0] : int'({live_resid, live_ovr, live_crc});
        string rq = avail ? "R3" : "R5";
        chk("R4", "avail", int'(cnt_hi[6]), int'(avail));
        chk("R7", "overflow", int'(cnt_hi[7]), int'(m_ovf));
        chk(rq, "count", int'({cnt_hi[5:0], cnt_lo}), ecnt);
        chk(rq, "resid", int'(st_reg[3:1]), (est >> 2) & 7);
        chk(rq, "ovr", int'(st_reg[5]), (est >> 1) & 1);
        chk(rq, "crc", int'(st_reg[6]), est & 1);
        chk("R6", "bypass", int'({st_reg[7], st_reg[4], st_reg[0]}),
            int'({live_eof, live_parity, live_all_sent}));
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic frame(input int n, input logic [2:0] r, input logic o, input logic c);
        flag_det = 1; tick(); flag_det = 0;
        for (int i = 0; i < n; i++) begin
            byte_stb = 1; tick();
        end
        byte_stb = 0;
        live_resid = r; live_ovr = o; live_crc = c; eof_stb = 1; tick();
        eof_stb = 0; live_resid = 0; live_ovr = 0; live_crc = 0; tick();
    endtask

    task automatic retire();
        status_read_done = 1; tick(); status_read_done = 0; tick();
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1; tick();
        chk("R9", "reset st_reg", int'(st_reg), 0);
        chk("R9", "reset cnt", int'({cnt_hi, cnt_lo}), 0);

        sdlc_mode = 1; fifo_en = 1; tick();
        // R1: counting, mode gating, flag priority
        flag_det = 1; tick(); flag_det = 0;
        repeat (5) begin byte_stb = 1; tick(); end
        byte_stb = 0; tick();
        chk("R1", "count after 5", int'(cnt_lo), 5);
        sdlc_mode = 0;
        repeat (3) begin byte_stb = 1; tick(); end
        byte_stb = 0; sdlc_mode = 1; tick();
        chk("R1", "count gated by mode", int'(cnt_lo), 5);
        flag_det = 1; byte_stb = 1; tick(); flag_det = 0; byte_stb = 0; tick();
        chk("R1", "flag wins", int'(cnt_lo), 0);

        // R3 empty retire ignored
        retire();
        chk("R3", "retire when empty", int'(cnt_hi[6]), 0);

        // R2 / R10 stored entries
        frame(3, 3'b101, 1'b1, 1'b0);
        chk("R2", "first len", int'(cnt_lo), 3);
        chk("R10", "status layout", int'(st_reg), 8'h2A);
        frame(7, 3'b010, 1'b0, 1'b1);
        frame(300, 3'b111, 1'b0, 1'b0);
        chk("R3", "oldest still shown", int'(cnt_lo), 3);

        // R6 bypass while queue shows stored bits
        live_crc = 0; live_eof = 1; live_parity = 1; live_all_sent = 1; live_resid = 3'b000;
        tick();
        chk("R6", "bypass mix", int'(st_reg), 8'hBB);
        live_eof = 0; live_parity = 0; live_all_sent = 0; tick();

        retire();
        chk("R3", "second len", int'(cnt_lo), 7);
        chk("R3", "second crc", int'(st_reg[6]), 1);
        retire();
        chk("R10", "hi bits", int'(cnt_hi[5:0]), 1);
        chk("R10", "lo bits", int'(cnt_lo), 44);
        retire();
        chk("R5", "empty shows live count", int'({cnt_hi[5:0], cnt_lo}), 300);
        live_ovr = 1; tick();
        chk("R5", "empty shows live ovr", int'(st_reg[5]), 1);
        live_ovr = 0; tick();

        // R7 overflow after the 11th frame
        for (int k = 1; k <= 11; k++) frame(k, 3'(k), 1'b0, 1'b0);
        chk("R7", "overflow flag", int'(cnt_hi[7]), 1);
        for (int k = 1; k <= 10; k++) begin
            chk("R7", "kept entry", int'(cnt_lo), k);
            retire();
        end
        chk("R7", "eleventh dropped", int'(cnt_hi[6]), 0);
        chk("R7", "flag sticky", int'(cnt_hi[7]), 1);

        // R8 flush on disable
        frame(4, 3'd1, 1'b0, 1'b0);
        frame(6, 3'd2, 1'b0, 1'b0);
        fifo_en = 0; tick();
        chk("R8", "overflow cleared", int'(cnt_hi[7]), 0);
        frame(9, 3'd3, 1'b1, 1'b1);
        fifo_en = 1; tick(); tick();
        chk("R8", "flushed and nothing stored", int'(cnt_hi[6]), 0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        finished = 1;
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nchk++; nerr++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule